// File: doc/BRIEF.md
# Floating-Point Compare to Condition Code

This unit compares two IEEE 754 floating-point operands and records the Boolean outcome in one of eight condition-code bits of a 32-bit floating-point control/status word. It handles single precision, double precision, and a paired-single format in which the two 32-bit halves of each operand are compared independently. Each half produces its own condition code.

The caller presents the operands, the format, the predicate, the result to force when the operands are unordered, an option that makes a quiet NaN signal an invalid operation, a condition-code index, and the current status word on `fcsr_in`. A one-cycle `start` strobe launches the compare. On the next cycle the unit presents the updated status word on `fcsr_out` and pulses `done`. Only the selected condition-code bits and the invalid-operation bits can change. Every other bit of `fcsr_in` is copied through unchanged.

NaN class follows the legacy convention. An operand with an all-ones exponent and a nonzero fraction is a NaN. It is quiet when the top fraction bit is 0 and signaling when that bit is 1.

Top module: `fcmp_ccu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `start`, `fcsr_out` is 0 and `done` is 0.
- R2: `done` is 1 in the cycle after a cycle with `start`=1 and is 0 otherwise. `fcsr_out` takes its new value in that same cycle and holds that value while `start` is 0.
- R3: `pred` selects the ordered predicate: 0 = equal, 1 = less-than (a < b), 2 = less-or-equal, 3 = never true.
- R4: +0 and -0 compare equal, so neither one is less than the other.
- R5: If either compared operand is a NaN and no invalid is raised, the condition-code bit written is `unord_val`.
- R6: Condition code 0 is status bit 23, and condition code n (1..7) is status bit 24+n.
- R7: Every status bit other than the written condition-code bits and the invalid bits 16 and 6 equals the corresponding bit of `fcsr_in` sampled with `start`.
- R8: When `sig_qnan` is 1 and either operand is a quiet NaN, status bits 16 and 6 are set and that compare's condition code keeps its `fcsr_in` value. A signaling NaN alone raises nothing and gives the unordered result.
- R9: `fmt` selects the format: 0 = single (bits 31:0 of each operand only), 1 = double (all 64 bits), 2 = paired-single, 3 = reserved (`fcsr_out` = `fcsr_in`).
- R10: In paired-single mode the low halves write condition code `cc_idx`, and the high halves write condition code (`cc_idx`+1) mod 8. Each half applies its own NaN and invalid checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a compare this cycle |
| fmt | input | 2 | Operand format select |
| pred | input | 2 | Ordered predicate select |
| unord_val | input | 1 | Result forced when operands are unordered |
| sig_qnan | input | 1 | Quiet NaN raises invalid and suppresses the update |
| cc_idx | input | 3 | Condition-code index |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| fcsr_in | input | 32 | Current status word |
| fcsr_out | output | 32 | Updated status word (registered) |
| done | output | 1 | Result valid pulse |

## Verification
The bench covers the following corner cases and the failure each one exposes:
- **Signed zero.** It compares +0 against -0. A plain bit compare would report them unequal and would order -0 below +0.
- **Two negative operands.** It compares two negative values. A magnitude compare that ignores the sign would invert the result.
- **NaN class.** It feeds both quiet and signaling NaNs with the signaling option on. A design that swaps the NaN classes would raise invalid on the wrong operand or would write the condition code when it must stay untouched.
- **Paired-single.** It runs paired-single with the index at 7, so the upper half must wrap to condition code 0, the only code that sits at a non-contiguous bit. It also raises invalid in one half only, to check that the other half still writes its result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int FCSR_W   = 32;
  localparam int CC_IDX_W = 3;

  localparam logic [4:0] CC0_POS       = 5'd23;
  localparam logic [4:0] CCN_BASE      = 5'd24;
  localparam logic [4:0] INV_CAUSE_POS = 5'd16;
  localparam logic [4:0] INV_FLAG_POS  = 5'd6;

  // Bits the unit may modify; everything else passes through.
  localparam logic [FCSR_W-1:0] MANAGED_MASK = 32'hFE81_0040;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'd0,
    FMT_DOUBLE = 2'd1,
    FMT_PAIRED = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    PRED_EQ    = 2'd0,
    PRED_LT    = 2'd1,
    PRED_LE    = 2'd2,
    PRED_NEVER = 2'd3
  } pred_e;

  typedef struct packed {
    logic upd;   // write the condition code
    logic cond;  // value to write
    logic inv;   // raise invalid operation
  } lane_res_t;

  function automatic logic [4:0] cc_pos(input logic [CC_IDX_W-1:0] idx);
    return (idx == '0) ? CC0_POS : (CCN_BASE + {2'b00, idx});
  endfunction

  function automatic logic [FCSR_W-1:0] apply_lane(input logic [FCSR_W-1:0] f,
                                                   input lane_res_t r,
                                                   input logic [CC_IDX_W-1:0] idx);
    logic [FCSR_W-1:0] o;
    o = f;
    if (r.inv) begin
      o[INV_CAUSE_POS] = 1'b1;
      o[INV_FLAG_POS]  = 1'b1;
    end
    if (r.upd) begin
      o[cc_pos(idx)] = r.cond;
    end
    return o;
  endfunction

endpackage

// File: rtl/fcmp_class.sv
module fcmp_class #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]   v,
  output logic           sign,
  output logic [W-2:0]   mag,
  output logic           is_zero,
  output logic           is_nan,
  output logic           is_qnan
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f   = v[W-2:FRAC_W];
    frac_f  = v[FRAC_W-1:0];
    sign    = v[W-1];
    mag     = v[W-2:0];
    is_zero = ~|v[W-2:0];
    is_nan  = (&exp_f) & (|frac_f);
    // legacy convention: top fraction bit clear means quiet
    is_qnan = is_nan & ~frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int MAG_W = 31
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             a_zero,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             b_zero,
  output logic             lt,
  output logic             eq
);
  always_comb begin
    eq = (a_zero & b_zero) | ((a_sign == b_sign) & (a_mag == b_mag));
    if (a_zero & b_zero) begin
      lt = 1'b0;
    end else if (a_sign != b_sign) begin
      lt = a_sign;
    end else if (!a_sign) begin
      lt = (a_mag < b_mag);
    end else begin
      lt = (a_mag > b_mag);
    end
  end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  pred_e        pred,
  input  logic         unord_val,
  input  logic         sig_qnan,
  output lane_res_t    res
);
  logic         a_s, b_s, a_z, b_z, a_n, b_n, a_q, b_q;
  logic [W-2:0] a_m, b_m;
  logic         lt, eq, ordered_res;

  fcmp_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .v(a), .sign(a_s), .mag(a_m), .is_zero(a_z), .is_nan(a_n), .is_qnan(a_q)
  );

  fcmp_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .v(b), .sign(b_s), .mag(b_m), .is_zero(b_z), .is_nan(b_n), .is_qnan(b_q)
  );

  fcmp_order #(.MAG_W(W-1)) u_ord (
    .a_sign(a_s), .a_mag(a_m), .a_zero(a_z),
    .b_sign(b_s), .b_mag(b_m), .b_zero(b_z),
    .lt(lt), .eq(eq)
  );

  always_comb begin
    unique case (pred)
      PRED_EQ:    ordered_res = eq;
      PRED_LT:    ordered_res = lt;
      PRED_LE:    ordered_res = lt | eq;
      default:    ordered_res = 1'b0;
    endcase
    res.inv  = sig_qnan & (a_q | b_q);
    res.upd  = ~res.inv;
    res.cond = (a_n | b_n) ? unord_val : ordered_res;
  end
endmodule

// File: rtl/fcmp_ccu.sv
module fcmp_ccu
  import fcmp_pkg::*;
#(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  parameter int LANES   = 2,
  localparam int SP_W   = 1 + SP_EXP + SP_FRAC,
  localparam int DP_W   = 1 + DP_EXP + DP_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        fmt,
  input  logic [1:0]        pred,
  input  logic              unord_val,
  input  logic              sig_qnan,
  input  logic [2:0]        cc_idx,
  input  logic [DP_W-1:0]   opa,
  input  logic [DP_W-1:0]   opb,
  input  logic [31:0]       fcsr_in,
  output logic [31:0]       fcsr_out,
  output logic              done
);
  pred_e               pred_s;
  fmt_e                fmt_s;
  lane_res_t           dp_res;
  lane_res_t           sp_res [LANES];
  logic [FCSR_W-1:0]   fcsr_d, fcsr_q;
  logic                done_q;
  logic [CC_IDX_W-1:0] cc_hi;

  assign pred_s = pred_e'(pred);
  assign fmt_s  = fmt_e'(fmt);
  assign cc_hi  = cc_idx + 3'd1;

  fcmp_lane #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp_lane (
    .a(opa), .b(opb), .pred(pred_s), .unord_val(unord_val),
    .sig_qnan(sig_qnan), .res(dp_res)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_sp
    fcmp_lane #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp_lane (
      .a(opa[g*SP_W +: SP_W]), .b(opb[g*SP_W +: SP_W]), .pred(pred_s),
      .unord_val(unord_val), .sig_qnan(sig_qnan), .res(sp_res[g])
    );
  end

  // next-state
  always_comb begin
    fcsr_d = fcsr_in;
    unique case (fmt_s)
      FMT_SINGLE: fcsr_d = apply_lane(fcsr_in, sp_res[0], cc_idx);
      FMT_DOUBLE: fcsr_d = apply_lane(fcsr_in, dp_res, cc_idx);
      FMT_PAIRED: fcsr_d = apply_lane(apply_lane(fcsr_in, sp_res[0], cc_idx),
                                      sp_res[1], cc_hi);
      default:    fcsr_d = fcsr_in;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcsr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start;
      if (start) begin
        fcsr_q <= fcsr_d;
      end
    end
  end

  assign fcsr_out = fcsr_q;
  assign done     = done_q;
endmodule

// File: rtl/fcmp_ccu_chk.sv
module fcmp_ccu_chk
  import fcmp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  fmt,
  input logic [1:0]  pred,
  input logic        unord_val,
  input logic        sig_qnan,
  input logic [2:0]  cc_idx,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic [31:0] fcsr_in,
  input logic [31:0] fcsr_out,
  input logic        done
);
  logic dp_a_nan, dp_a_qnan, sp_zero_pair;
  assign dp_a_nan     = (&opa[62:52]) & (|opa[51:0]);
  assign dp_a_qnan    = dp_a_nan & ~opa[51];
  assign sp_zero_pair = (opa[30:0] == 31'd0) & (opb[30:0] == 31'd0);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (fcsr_out == 32'd0 && done == 1'b0); // R1
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R2

  AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(fcsr_out)); // R2

  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fmt == 2'd0 && pred == 2'd0 && !sig_qnan && cc_idx == 3'd0 && sp_zero_pair)
    |=> fcsr_out[23]); // R4

  AST_UNORD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fmt == 2'd1 && !sig_qnan && cc_idx == 3'd0 && dp_a_nan)
    |=> fcsr_out[23] == $past(unord_val)); // R5

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((fcsr_out & ~MANAGED_MASK) == ($past(fcsr_in) & ~MANAGED_MASK))); // R7

  AST_QNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fmt == 2'd1 && sig_qnan && dp_a_qnan)
    |=> (fcsr_out[16] && fcsr_out[6] &&
         fcsr_out[31:23] == $past(fcsr_in[31:23]))); // R8

  AST_RESERVED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fmt == 2'd3) |=> fcsr_out == $past(fcsr_in)); // R9
endmodule

bind fcmp_ccu fcmp_ccu_chk u_chk (.*);

// File: tb/fcmp_ccu_test.sv
`timescale 1ns/1ps
module fcmp_ccu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  fmt, pred;
  logic        unord_val, sig_qnan;
  logic [2:0]  cc_idx;
  logic [63:0] opa, opb;
  logic [31:0] fcsr_in;
  logic [31:0] fcsr_out;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [31:0] S_ONE  = 32'h3F80_0000;
  localparam logic [31:0] S_TWO  = 32'h4000_0000;
  localparam logic [31:0] S_MONE = 32'hBF80_0000;
  localparam logic [31:0] S_MTWO = 32'hC000_0000;
  localparam logic [31:0] S_PZ   = 32'h0000_0000;
  localparam logic [31:0] S_MZ   = 32'h8000_0000;
  localparam logic [31:0] S_QNAN = 32'h7FBF_FFFF;
  localparam logic [31:0] S_SNAN = 32'h7FC0_0000;
  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF7_FFFF_FFFF_FFFF;

  fcmp_ccu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .pred(pred),
    .unord_val(unord_val), .sig_qnan(sig_qnan), .cc_idx(cc_idx),
    .opa(opa), .opb(opb), .fcsr_in(fcsr_in), .fcsr_out(fcsr_out), .done(done)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] ccbit(input int n);
    return (n == 0) ? (32'd1 << 23) : (32'd1 << (24 + n));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] f, input logic [1:0] p, input logic uv,
                      input logic sq, input logic [2:0] cc, input logic [63:0] a,
                      input logic [63:0] b, input logic [31:0] fin);
    @(negedge clk);
    fmt = f; pred = p; unord_val = uv; sig_qnan = sq; cc_idx = cc;
    opa = a; opb = b; fcsr_in = fin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done pulse", {31'd0, done}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 reset fcsr", fcsr_out, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_single_pred;
    fire(2'd0, 2'd0, 1'b0, 1'b0, 3'd0, {32'd0, S_ONE}, {32'd0, S_ONE}, 32'd0);
    chk("R3 R6 eq cc0", fcsr_out, ccbit(0));
    @(negedge clk);
    chk("R2 done low", {31'd0, done}, 32'd0);
    chk("R2 hold", fcsr_out, ccbit(0));
    fire(2'd0, 2'd1, 1'b0, 1'b0, 3'd3, {32'd0, S_MONE}, {32'd0, S_ONE}, 32'h0000_0A5A);
    chk("R3 R7 lt cc3", fcsr_out, 32'h0800_0A5A);
    fire(2'd0, 2'd1, 1'b0, 1'b0, 3'd3, {32'd0, S_TWO}, {32'd0, S_ONE}, 32'hFFFF_FFFF);
    chk("R3 lt false clears", fcsr_out, 32'hFFFF_FFFF & ~ccbit(3));
    fire(2'd0, 2'd1, 1'b0, 1'b0, 3'd2, {32'd0, S_MTWO}, {32'd0, S_MONE}, 32'd0);
    chk("R3 negative lt", fcsr_out, ccbit(2));
    fire(2'd0, 2'd2, 1'b0, 1'b0, 3'd5, {32'd0, S_ONE}, {32'd0, S_ONE}, 32'd0);
    chk("R3 le equal", fcsr_out, ccbit(5));
    fire(2'd0, 2'd3, 1'b1, 1'b0, 3'd5, {32'd0, S_ONE}, {32'd0, S_ONE}, ccbit(5));
    chk("R3 never", fcsr_out, 32'd0);
  endtask

  task automatic t_zeros;
    fire(2'd0, 2'd0, 1'b0, 1'b0, 3'd1, {32'd0, S_PZ}, {32'd0, S_MZ}, 32'd0);
    chk("R4 +0 eq -0", fcsr_out, ccbit(1));
    fire(2'd0, 2'd1, 1'b0, 1'b0, 3'd1, {32'd0, S_MZ}, {32'd0, S_PZ}, ccbit(1));
    chk("R4 -0 not lt +0", fcsr_out, 32'd0);
  endtask

  task automatic t_nan;
    fire(2'd0, 2'd0, 1'b1, 1'b0, 3'd4, {32'd0, S_SNAN}, {32'd0, S_ONE}, 32'd0);
    chk("R5 unord true", fcsr_out, ccbit(4));
    fire(2'd0, 2'd2, 1'b0, 1'b0, 3'd4, {32'd0, S_ONE}, {32'd0, S_SNAN}, ccbit(4));
    chk("R5 unord false", fcsr_out, 32'd0);
    fire(2'd0, 2'd0, 1'b1, 1'b1, 3'd4, {32'd0, S_SNAN}, {32'd0, S_ONE}, 32'd0);
    chk("R8 snan no invalid", fcsr_out, ccbit(4));
    fire(2'd0, 2'd0, 1'b0, 1'b1, 3'd2, {32'd0, S_ONE}, {32'd0, S_QNAN}, 32'h0400_0000);
    chk("R8 qnan invalid", fcsr_out, 32'h0401_0040);
    fire(2'd0, 2'd0, 1'b0, 1'b0, 3'd2, {32'd0, S_ONE}, {32'd0, S_QNAN}, 32'h0400_0000);
    chk("R5 qnan quiet mode", fcsr_out, 32'd0);
  endtask

  task automatic t_formats;
    fire(2'd1, 2'd1, 1'b0, 1'b0, 3'd7, D_ONE, D_TWO, 32'd0);
    chk("R9 double lt cc7", fcsr_out, ccbit(7));
    fire(2'd1, 2'd0, 1'b0, 1'b1, 3'd0, D_QNAN, D_ONE, 32'h0080_0000);
    chk("R8 double qnan", fcsr_out, 32'h0081_0040);
    fire(2'd0, 2'd0, 1'b0, 1'b0, 3'd6, {32'hFFFF_FFFF, S_ONE}, {32'd0, S_ONE}, 32'd0);
    chk("R9 single ignores upper", fcsr_out, ccbit(6));
    fire(2'd3, 2'd0, 1'b1, 1'b1, 3'd0, D_ONE, D_ONE, 32'h1234_5678);
    chk("R9 reserved copy", fcsr_out, 32'h1234_5678);
  endtask

  task automatic t_paired;
    fire(2'd2, 2'd0, 1'b0, 1'b0, 3'd4, {S_TWO, S_ONE}, {S_ONE, S_ONE}, 32'h2000_0000);
    chk("R10 paired cc4/cc5", fcsr_out, ccbit(4));
    fire(2'd2, 2'd1, 1'b0, 1'b0, 3'd7, {S_ONE, S_MONE}, {S_TWO, S_ONE}, 32'd0);
    chk("R10 paired wrap", fcsr_out, ccbit(7) | ccbit(0));
    fire(2'd2, 2'd0, 1'b0, 1'b1, 3'd2, {S_QNAN, S_ONE}, {S_ONE, S_ONE}, ccbit(3));
    chk("R10 half invalid", fcsr_out, ccbit(2) | ccbit(3) | 32'h0001_0040);
  endtask

  initial begin
    start = 1'b0; fmt = '0; pred = '0; unord_val = 1'b0; sig_qnan = 1'b0;
    cc_idx = '0; opa = '0; opb = '0; fcsr_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single_pred;
    t_zeros;
    t_nan;
    t_formats;
    t_paired;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule